// File: doc/BRIEF.md
# Early-Terminating Radix-8 Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over several clock cycles and returns a 32-bit quotient. It treats the operands as signed or unsigned, as selected when the operation starts. Each iteration cycle runs three restoring subtract-and-shift steps in a chain, so it adds three quotient bits per cycle.

When the operation is accepted, the dividend is aligned so that its leading zeros are never iterated. Only the 3-bit groups that hold significant bits are processed, which means small dividends finish quickly. In signed mode one extra cycle first replaces both operands with their magnitudes. The quotient sign is applied when the last group is retired.

A caller pulses `start` together with the operands while `busy` is low. It then waits for the one-cycle `done` pulse, after which `quotient` holds the result until the next operation completes.

Top module: `early_radix8_div`

## Requirements
- R1: While reset is asserted, and after it is released, `busy` and `done` are low and `quotient` is zero.
- R2: With `signed_mode` low and a nonzero divisor, the quotient is the unsigned floor of dividend divided by divisor.
- R3: With `signed_mode` high and a nonzero divisor, the quotient is the two's-complement quotient truncated toward zero. Its sign is the XOR of the operand sign bits (bit 31), and a negative result is the negated magnitude quotient.
- R4: A zero divisor gives a quotient of 0 in either mode, with `done` two cycles after the start cycle.
- R5: Let k be the bit length of the dividend (highest set bit index plus one, 0 for zero) and let n = max(1, ceil(k/3)). With `signed_mode` low and a nonzero divisor, `done` rises n+1 cycles after the start cycle. This gives 2 to 12 cycles.
- R6: With `signed_mode` high and a nonzero divisor, `done` rises n+2 cycles after the start cycle, where k is taken from the dividend's magnitude.
- R7: In signed mode, 0x80000000 divided by 0xFFFFFFFF returns 0x80000000.
- R8: `busy` is high from the cycle after an accepted start up to the cycle before `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R9: A `start` pulse while `busy` is high is ignored. The running operation keeps its quotient and its latency.
- R10: `quotient` keeps its value from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken only while idle |
| signed_mode | input | 1 | 1 selects two's-complement operands |
| dividend | input | 32 | Dividend, sampled with start |
| divisor | input | 32 | Divisor, sampled with start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result, valid from done onward |

## Verification
The hardest case to reach from the ports is a long iteration whose final group carries a sign correction, with a second start arriving mid-run. Long runs need dividends with high set bits, the sign correction needs operands of mixed signs in signed mode, and the stray start must land while `busy` is high. Random dividends are shifted right by a random amount so that every group count from 1 to 11 appears. Signed and unsigned runs are mixed at random. Directed runs inject a second start in the third cycle of any operation that lasts long enough and add the most-negative-by-minus-one and zero-divisor cases.

// File: rtl/erd_pkg.sv
package erd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2
  } erd_state_e;

endpackage

// File: rtl/erd_lzc.sv
module erd_lzc #(
  parameter int W  = 32,
  parameter int ZW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [ZW-1:0] zeros
);

  // Priority scan: the highest set bit wins, all-zero gives W.
  always_comb begin
    zeros = ZW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) zeros = ZW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/erd_align.sv
module erd_align #(
  parameter int W   = 32,
  parameter int SPC = 3,
  parameter int NG  = (W + SPC - 1) / SPC,
  parameter int GW  = NG * SPC,
  parameter int CW  = $clog2(NG + 1)
) (
  input  logic [W-1:0]  mag,
  output logic [GW-1:0] aligned,
  output logic [CW-1:0] groups
);

  localparam int ZW = $clog2(W + 1);

  logic [ZW-1:0] lead;

  erd_lzc #(.W(W), .ZW(ZW)) u_lzc (
    .val   (mag),
    .zeros (lead)
  );

  // The significant bits are padded up to whole groups and moved to the top.
  always_comb begin
    int sig_bits;
    int grp;
    sig_bits = W - int'(lead);
    grp      = (sig_bits + SPC - 1) / SPC;
    if (grp < 1) grp = 1;
    groups   = CW'(grp);
    aligned  = GW'(mag) << (GW - SPC * grp);
  end

endmodule

// File: rtl/erd_step.sv
module erd_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] dvs,
  input  logic         bit_in,
  output logic [W-1:0] rem_out,
  output logic         q_bit
);

  logic [W:0] trial;
  logic [W:0] diff;

  // Restoring step: the borrow out of the trial subtraction decides the bit.
  always_comb begin
    trial   = {rem_in, bit_in};
    diff    = trial - {1'b0, dvs};
    q_bit   = ~diff[W];
    rem_out = q_bit ? diff[W-1:0] : trial[W-1:0];
  end

endmodule

// File: rtl/early_radix8_div.sv
module early_radix8_div
  import erd_pkg::*;
#(
  parameter int W   = 32,
  parameter int SPC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int NG = (W + SPC - 1) / SPC;
  localparam int GW = NG * SPC;
  localparam int CW = $clog2(NG + 1);

  erd_state_e    state_q, state_d;
  logic [GW-1:0] dvd_q, dvd_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          neg_q, neg_d;
  logic          done_q, done_d;
  logic [W-1:0]  qout_q, qout_d;
  logic          data_en;

  logic [W-1:0]  mag_sel;
  logic [GW-1:0] al_vec;
  logic [CW-1:0] al_groups;
  logic [W-1:0]  rem_c [SPC+1];
  logic [SPC-1:0] qgrp;
  logic [W-1:0]  quo_nx;

  function automatic logic [W-1:0] mag_of(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  // Alignment source: the raw port when unsigned, the stored operand's magnitude in PREP.
  assign mag_sel = (state_q == ST_IDLE) ? dividend : mag_of(dvd_q[W-1:0]);

  erd_align #(.W(W), .SPC(SPC), .NG(NG), .GW(GW), .CW(CW)) u_align (
    .mag     (mag_sel),
    .aligned (al_vec),
    .groups  (al_groups)
  );

  // Cascade of SPC restoring steps, fed from the top bits of the aligned dividend.
  assign rem_c[0] = rem_q;

  for (genvar j = 0; j < SPC; j++) begin : g_step
    erd_step #(.W(W)) u_step (
      .rem_in  (rem_c[j]),
      .dvs     (dvs_q),
      .bit_in  (dvd_q[GW-1-j]),
      .rem_out (rem_c[j+1]),
      .q_bit   (qgrp[SPC-1-j])
    );
  end

  assign quo_nx = {quo_q[W-SPC-1:0], qgrp};

  assign data_en = start || (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    dvd_d   = dvd_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    quo_d   = quo_q;
    cnt_d   = cnt_q;
    neg_d   = neg_q;
    done_d  = 1'b0;
    qout_d  = qout_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          rem_d = '0;
          quo_d = '0;
          dvs_d = divisor;
          neg_d = 1'b0;
          if (divisor == '0) begin
            dvd_d   = '0;
            cnt_d   = CW'(1);
            state_d = ST_ITER;
          end else if (signed_mode) begin
            dvd_d   = GW'(dividend);
            neg_d   = dividend[W-1] ^ divisor[W-1];
            state_d = ST_PREP;
          end else begin
            dvd_d   = al_vec;
            cnt_d   = al_groups;
            state_d = ST_ITER;
          end
        end
      end
      ST_PREP: begin
        dvs_d   = mag_of(dvs_q);
        dvd_d   = al_vec;
        cnt_d   = al_groups;
        state_d = ST_ITER;
      end
      ST_ITER: begin
        dvd_d = dvd_q << SPC;
        rem_d = rem_c[SPC];
        quo_d = quo_nx;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (dvs_q == '0)
            qout_d = '0;
          else
            qout_d = neg_q ? (~quo_nx + 1'b1) : quo_nx;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      qout_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (done_d) qout_q <= qout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      neg_q <= 1'b0;
    end else if (data_en) begin
      dvd_q <= dvd_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      quo_q <= quo_d;
      cnt_q <= cnt_d;
      neg_q <= neg_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign quotient = qout_q;

endmodule

// File: rtl/early_radix8_div_chk.sv
module early_radix8_div_chk #(
  parameter int W   = 32,
  parameter int SPC = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         signed_mode,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient
);

  localparam int NG = (W + SPC - 1) / SPC;
  localparam int BW = $clog2(NG + 3);

  logic [BW-1:0] busy_run;

  // Counts consecutive busy cycles so the latency ceiling is checked without deep $past.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(quotient));

  a_r4_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |-> ##2 (done && quotient == '0));

  a_r6_latency_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run <= BW'(NG)));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  logic unused_ok;
  assign unused_ok = signed_mode ^ (|dividend);

endmodule

bind early_radix8_div early_radix8_div_chk #(.W(W), .SPC(SPC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .signed_mode (signed_mode),
  .dividend    (dividend),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient)
);

// File: tb/early_radix8_div_test.sv
module early_radix8_div_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        signed_mode;
  logic [31:0] dividend;
  logic [31:0] divisor;
  logic        busy;
  logic        done;
  logic [31:0] quotient;

  int checks = 0;
  int fails  = 0;

  early_radix8_div uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint mag64(input logic [31:0] v, input bit s);
    longint x;
    x = s ? longint'($signed(v)) : longint'(v);
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [31:0] ref_quot(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint q;
    if (b == 0) return 32'd0;
    if (!s) return a / b;
    q = mag64(a, 1) / mag64(b, 1);
    if (a[31] ^ b[31]) q = -q;
    return q[31:0];
  endfunction

  function automatic int ref_lat(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint m;
    int k;
    int n;
    if (b == 0) return 2;
    m = mag64(a, s);
    k = 0;
    for (int i = 0; i < 33; i++) if ((m >> i) != 0) k = i + 1;
    n = (k + 2) / 3;
    if (n < 1) n = 1;
    return s ? n + 2 : n + 1;
  endfunction

  // Runs one operation; inputs change on the falling edge, outputs are read there too.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input bit inject, input string req);
    logic [31:0] expq;
    int explat;
    int cyc;
    expq   = ref_quot(a, b, s);
    explat = ref_lat(a, b, s);
    dividend    = a;
    divisor     = b;
    signed_mode = s;
    start       = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    dividend = ~a;
    divisor  = b + 32'd3;
    cyc = 1;
    check(busy && !done, "R8", "busy after start", {busy, done}, 2'b10);
    while (!done && cyc < 40) begin
      if (inject && cyc == 2) begin
        start       = 1'b1;
        signed_mode = ~s;
        dividend    = 32'h0000_0001;
        divisor     = 32'h0000_0001;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(quotient == expq, req, "quotient", quotient, expq);
    check(cyc == explat, inject ? "R9" : (s ? "R6" : "R5"), "latency", cyc, explat);
    check(!busy, "R8", "busy low with done", busy, 0);
    @(negedge clk);
    check(!done && quotient == expq, "R10", "hold after done", quotient, expq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8: actual no completion, expected end of run");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ra;
    logic [31:0] rb;
    void'($urandom(32'd2718));
    rst_n       = 1'b0;
    start       = 1'b0;
    signed_mode = 1'b0;
    dividend    = '0;
    divisor     = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && quotient == 0, "R1", "reset state", quotient, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && quotient == 0, "R1", "after release", quotient, 0);

    run_op(32'd100, 32'd7, 1'b0, 1'b0, "R2");
    run_op(32'd0, 32'd5, 1'b0, 1'b0, "R2");
    run_op(32'd5, 32'd7, 1'b0, 1'b0, "R2");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R2");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2");
    run_op(32'd7, 32'd1, 1'b0, 1'b0, "R2");
    run_op(32'd8, 32'd1, 1'b0, 1'b0, "R2");
    run_op(32'h1234_5678, 32'd0, 1'b0, 1'b0, "R4");
    run_op(32'h8765_4321, 32'd0, 1'b1, 1'b0, "R4");
    run_op(-32'sd7, 32'd2, 1'b1, 1'b0, "R3");
    run_op(32'd7, -32'sd2, 1'b1, 1'b0, "R3");
    run_op(-32'sd7, -32'sd2, 1'b1, 1'b0, "R3");
    run_op(32'h7FFF_FFFF, 32'd3, 1'b1, 1'b0, "R3");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R3");
    run_op(32'hDEAD_BEEF, 32'd13, 1'b0, 1'b1, "R9");
    run_op(-32'sd1000000, 32'd9, 1'b1, 1'b1, "R9");

    for (int i = 0; i < 400; i++) begin
      ra = $urandom() >> ($urandom() % 32);
      rb = $urandom() >> ($urandom() % 32);
      if ($urandom() % 16 == 0) rb = 32'd0;
      if ($urandom() % 4 == 0) ra = -ra;
      if ($urandom() % 4 == 0) rb = -rb;
      if ($urandom() % 2 == 0) run_op(ra, rb, 1'b1, ($urandom() % 8) == 0, "R3");
      else                     run_op(ra, rb, 1'b0, ($urandom() % 8) == 0, "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule